// File: doc/BRIEF.md
# System configuration register bank

This block is a small bank of 32-bit configuration registers behind a single-cycle register port. A write is presented as a byte offset, a data word and a write strobe, and it takes effect at the next rising clock edge. A read is purely combinational: the read word follows the offset in the same cycle. Every field obeys its own access rule. Some bits are plain read/write and some are reserved. Some can only be set, one can only be cleared, and one is write-one-to-clear. Only reset returns the set-only bits to zero.

The same bank also routes GPIO pin levels onto sixteen external-interrupt lines. Four selection registers each hold four 4-bit port codes, so each line has its own code. The line then follows the level of its own pin number on the chosen port. The routing is combinational. Edge detection, masking and pending state are left to the interrupt controller that consumes the lines.

Top module: `sys_cfg_bank`

## Requirements
- R1: After reset, offset 0x04 reads 0x7C000001 and every other offset from 0x00 to 0x28 reads 0.
- R2: Bits outside the writable set ignore writes and read 0. The writable masks are 0x107 at offset 0x00, 0x0000FFFF at offsets 0x08, 0x0C, 0x10 and 0x14, and 0xFF at offset 0x24. Offset 0x18 has no writable bits.
- R3: Ordinary read/write bits can be both set and cleared. These are the masks listed in R2 and mask 0xFCFF0100 at offset 0x04.
- R4: Bit 0 at offset 0x04 is clear-only. A write of 0 clears it, and a later write of 1 leaves it at 0 until reset.
- R5: Bits 25:24 at offset 0x04 keep their reset value of 0 whatever is written.
- R6: Bits 3:0 at offset 0x1C are set-only. A 1 sets a bit, a 0 leaves it unchanged, and only reset clears it.
- R7: Bit 8 at offset 0x1C is write-one-to-clear. Writing 1 to it never sets it, so it reads 0 after such a write.
- R8: All 32 bits at offsets 0x20 and 0x28 are set-only. Only reset clears them.
- R9: Interrupt line n takes its 4-bit port code from the selection register at offset 0x08 + 4*(n/4), bits 4*(n%4)+3 down to 4*(n%4).
- R10: The pin input vector is indexed as 16*port + pin. Line n equals input 16*c + n, where c is the line's port code. Pins of other ports have no effect on line n.
- R11: A port code of 8 or more drives its line to 0.
- R12: An offset that is not a multiple of 4, or that is 0x2C or above, reads 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current offset |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 128 | GPIO pin levels, 16 per port, index 16*port + pin |
| irq_line | output | 16 | Routed external-interrupt lines |

## Verification
The hardest states to reach from the ports are the ones that build up over a history of writes. These are set-only words that have picked up ones from many writes, and the clear-only bit after it has been dropped. Only a reset can undo either of them. The bench drives both with directed write sequences and applies reset in the middle of a run to show that reset is the only way back. Random writes then hit every offset, including invalid and misaligned ones. The port-code nibbles are biased so that codes just above the implemented port count appear often. Each random write is paired with a new random pin vector, so each routed line is compared against a reference that selects the port independently of the design.

// File: rtl/sys_cfg_bank.sv
module sys_cfg_bank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int LINES  = 16,
  parameter int PORTS  = 8,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  input  logic [PORTS*LINES-1:0]   pin_in,
  output logic [LINES-1:0]         irq_line
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int FPR      = 4;
  localparam int SEL_REGS = LINES / FPR;
  localparam int SELR_W   = FPR * SEL_W;
  localparam int SIX_W    = (SEL_REGS > 1) ? $clog2(SEL_REGS) : 1;
  localparam int PIX_W    = (PORTS > 1) ? $clog2(PORTS) : 1;
  localparam int N_SOFT   = 4;

  localparam logic [IDX_W-1:0] IX_REMAP = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_CFG1  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_SEL0  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IX_STAT  = IDX_W'(2 + SEL_REGS);
  localparam logic [IDX_W-1:0] IX_CFG2  = IDX_W'(3 + SEL_REGS);
  localparam logic [IDX_W-1:0] IX_SWP1  = IDX_W'(4 + SEL_REGS);
  localparam logic [IDX_W-1:0] IX_KEY   = IDX_W'(5 + SEL_REGS);
  localparam logic [IDX_W-1:0] IX_SWP2  = IDX_W'(6 + SEL_REGS);

  localparam logic [DATA_W-1:0] REMAP_M  = DATA_W'(32'h0000_0107);
  localparam logic [DATA_W-1:0] CFG1_RW  = DATA_W'(32'hFCFF_0100);
  localparam logic [DATA_W-1:0] CFG1_RST = DATA_W'(32'h7C00_0001);
  localparam logic [DATA_W-1:0] KEY_M    = DATA_W'(32'h0000_00FF);

  logic [IDX_W-1:0]    idx;
  logic                addr_ok;
  logic                wr_hit;
  logic [DATA_W-1:0]   remap_q, cfg1_q, swp1_q, swp2_q, key_q;
  logic [N_SOFT-1:0]   cfg2_q;
  logic [SELR_W-1:0]   sel_q [SEL_REGS];
  logic [SIX_W-1:0]    sel_pick;

  assign idx      = addr[ADDR_W-1:2];
  assign addr_ok  = (addr[1:0] == 2'b00) && (idx <= IX_SWP2);
  assign wr_hit   = wr_en && addr_ok;
  assign sel_pick = SIX_W'(idx - IX_SEL0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remap_q <= '0;
      cfg1_q  <= CFG1_RST;
      cfg2_q  <= '0;
      swp1_q  <= '0;
      swp2_q  <= '0;
      key_q   <= '0;
    end else if (wr_hit) begin
      case (idx)
        IX_REMAP: remap_q <= wdata & REMAP_M;
        IX_CFG1:  cfg1_q  <= (wdata & CFG1_RW) | DATA_W'(cfg1_q[0] & wdata[0]);
        IX_CFG2:  cfg2_q  <= cfg2_q | wdata[N_SOFT-1:0];
        IX_SWP1:  swp1_q  <= swp1_q | wdata;
        IX_KEY:   key_q   <= wdata & KEY_M;
        IX_SWP2:  swp2_q  <= swp2_q | wdata;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < SEL_REGS; k++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n)
        sel_q[k] <= '0;
      else if (wr_hit && idx == IX_SEL0 + IDX_W'(k))
        sel_q[k] <= wdata[SELR_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr_ok) begin
      case (idx)
        IX_REMAP: rdata = remap_q;
        IX_CFG1:  rdata = cfg1_q;
        IX_STAT:  rdata = '0;
        IX_CFG2:  rdata = DATA_W'(cfg2_q);
        IX_SWP1:  rdata = swp1_q;
        IX_KEY:   rdata = key_q;
        IX_SWP2:  rdata = swp2_q;
        default:  rdata = DATA_W'(sel_q[sel_pick]);
      endcase
    end
  end

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [SEL_W-1:0] code;
    logic [PORTS-1:0] col;
    assign code = sel_q[n / FPR][SEL_W*(n % FPR) +: SEL_W];
    for (genvar p = 0; p < PORTS; p++) begin : g_col
      assign col[p] = pin_in[p*LINES + n];
    end
    assign irq_line[n] = ({1'b0, code} < (SEL_W+1)'(PORTS)) ? col[PIX_W'(code)] : 1'b0;

    // R11
    bad_code_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, code} >= (SEL_W+1)'(PORTS)) |-> !irq_line[n]);
  end

  // R4
  clr_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg1_q[0] |=> !cfg1_q[0]);

  // R6
  cfg2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~cfg2_q & $past(cfg2_q)) == '0));

  // R8
  swp1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~swp1_q & $past(swp1_q)) == '0));

  // R8
  swp2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~swp2_q & $past(swp2_q)) == '0));

  // R5
  cfg1_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ok && idx == IX_CFG1) |-> (rdata[25:24] == 2'b00));

  // R12
  bad_addr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> (rdata == '0));

endmodule

// File: tb/sys_cfg_bank_tb.sv
module sys_cfg_bank_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [127:0] pin_in = '0;
  logic [15:0]  irq_line;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] mdl [11];

  always #10 clk = ~clk;

  sys_cfg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .irq_line(irq_line)
  );

  function automatic bit off_ok(logic [7:0] off);
    return (off[1:0] == 2'b00) && (off < 8'h2C);
  endfunction

  function automatic logic [31:0] next_val(logic [7:0] off, logic [31:0] old, logic [31:0] w);
    case (off)
      8'h00: return w & 32'h107;
      8'h04: return (w & 32'hFCFF_0100) | (old & w & 32'h1);
      8'h08, 8'h0C, 8'h10, 8'h14: return w & 32'hFFFF;
      8'h1C: return (old | w) & 32'hF;
      8'h20, 8'h28: return old | w;
      8'h24: return w & 32'hFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] off);
    return off_ok(off) ? mdl[off >> 2] : 32'h0;
  endfunction

  function automatic logic [15:0] exp_irq(logic [127:0] pins);
    logic [15:0] r = '0;
    for (int n = 0; n < 16; n++) begin
      logic [31:0] c = (mdl[2 + n/4] >> (4*(n%4))) & 32'hF;
      r[n] = (c < 8) ? pins[16*c + n] : 1'b0;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 11; i++) mdl[i] = (i == 1) ? 32'h7C00_0001 : 32'h0;
  endtask

  task automatic wr(logic [7:0] off, logic [31:0] val);
    @(negedge clk);
    addr = off;
    wdata = val;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (off_ok(off)) mdl[off >> 2] = next_val(off, mdl[off >> 2], val);
  endtask

  task automatic rd(string req, logic [7:0] off);
    @(negedge clk);
    addr = off;
    #2;
    chk(req, rdata, exp_rd(off));
  endtask

  task automatic pins(string req, logic [127:0] v);
    @(negedge clk);
    pin_in = v;
    #2;
    chk(req, {16'h0, irq_line}, {16'h0, exp_irq(v)});
  endtask

  task automatic pin_bit(string req, int b, logic expv, int line);
    @(negedge clk);
    pin_in = '0;
    pin_in[b] = 1'b1;
    #2;
    chk(req, {31'h0, irq_line[line]}, {31'h0, expv});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    // R1 reset state
    for (int o = 0; o <= 8'h2C; o += 4) rd("R1", 8'(o));
    chk("R1", {16'h0, irq_line}, 32'h0);

    // R2 reserved bits
    wr(8'h00, 32'hFFFF_FEF8); rd("R2", 8'h00);
    wr(8'h04, 32'h7F00_FEFF); rd("R5", 8'h04);
    for (int o = 8'h08; o <= 8'h14; o += 4) begin
      wr(8'(o), 32'hFFFF_0000); rd("R2", 8'(o));
    end
    wr(8'h24, 32'hFFFF_FF00); rd("R2", 8'h24);
    wr(8'h18, 32'hFFFF_FFFF); rd("R2", 8'h18);

    // R3 set and clear
    wr(8'h00, 32'h107); rd("R3", 8'h00);
    wr(8'h00, 32'h0);   rd("R3", 8'h00);
    wr(8'h04, 32'hFCFF_0101); rd("R3", 8'h04);
    wr(8'h04, 32'h1);         rd("R3", 8'h04);
    for (int o = 8'h08; o <= 8'h14; o += 4) begin
      wr(8'(o), 32'hFFFF); rd("R3", 8'(o));
      wr(8'(o), 32'h0);    rd("R3", 8'(o));
    end
    wr(8'h24, 32'hFF); rd("R3", 8'h24);
    wr(8'h24, 32'h0);  rd("R3", 8'h24);
    wr(8'h04, 32'hFFFF_FFFF); rd("R5", 8'h04);
    chk("R5", rdata & 32'h0300_0000, 32'h0);

    // R7 write-one-to-clear bit
    wr(8'h1C, 32'h100); rd("R7", 8'h1C);
    chk("R7", rdata & 32'h100, 32'h0);

    // R6, R8 set-only, cleared only by reset
    wr(8'h1C, 32'hF); wr(8'h1C, 32'h0); rd("R6", 8'h1C);
    chk("R6", rdata, 32'hF);
    wr(8'h20, 32'hFFFF_FFFF); wr(8'h20, 32'h0); rd("R8", 8'h20);
    chk("R8", rdata, 32'hFFFF_FFFF);
    wr(8'h28, 32'hA5A5_0000); wr(8'h28, 32'h0000_5A5A); wr(8'h28, 32'h0); rd("R8", 8'h28);
    chk("R8", rdata, 32'hA5A5_5A5A);
    do_reset();
    rd("R6", 8'h1C); rd("R8", 8'h20); rd("R8", 8'h28);

    // R4 clear-only bit
    wr(8'h04, 32'h0); wr(8'h04, 32'h1); rd("R4", 8'h04);
    chk("R4", rdata, 32'h0);
    do_reset();
    rd("R4", 8'h04);

    // R12 invalid offsets
    wr(8'h2C, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF); wr(8'h05, 32'hFFFF_FFFF); wr(8'h22, 32'hFFFF_FFFF);
    rd("R12", 8'h2C); rd("R12", 8'h05); rd("R12", 8'h22); rd("R12", 8'hFC);
    for (int o = 0; o < 8'h2C; o += 4) rd("R12", 8'(o));

    // R9, R10 directed routing
    pin_bit("R10", 0, 1'b1, 0);
    pin_bit("R10", 15, 1'b1, 15);
    pin_bit("R10", 16, 1'b0, 0);
    wr(8'h0C, 32'h0000_2000);
    pin_bit("R9", 16*2 + 7, 1'b1, 7);
    pin_bit("R9", 7, 1'b0, 7);
    wr(8'h08, 32'h0000_0010);
    pin_bit("R9", 17, 1'b1, 1);
    wr(8'h08, 32'h0000_0001);
    pin_bit("R10", 0, 1'b0, 0);
    pin_bit("R10", 16, 1'b1, 0);
    pin_bit("R10", 17, 1'b0, 1);

    // R11 codes beyond the implemented ports
    wr(8'h08, 32'h0000_0008);
    pins("R11", '1);
    chk("R11", {31'h0, irq_line[0]}, 32'h0);
    wr(8'h14, 32'hF000);
    pins("R11", '1);
    chk("R11", {31'h0, irq_line[15]}, 32'h0);

    // random mix: R2 R3 R4 R6 R8 R9 R10 R11 R12
    for (int it = 0; it < 400; it++) begin
      logic [7:0] off;
      logic [31:0] d;
      logic [127:0] pv;
      if ($urandom % 8 == 0) off = 8'($urandom);
      else off = 8'(4 * ($urandom % 12));
      d = $urandom;
      if (off >= 8'h08 && off <= 8'h14)
        for (int f = 0; f < 4; f++) d[4*f +: 4] = 4'($urandom % 10);
      if ((off == 8'h04) && ($urandom % 4 != 0)) d[0] = 1'b1;
      wr(off, d);
      rd("R12", off);
      rd("R3", 8'(4 * ($urandom % 11)));
      pv = {$urandom, $urandom, $urandom, $urandom};
      pins("R10", pv);
      if (it % 100 == 99) do_reset();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule